// File: doc/BRIEF.md
# Shared Mailbox Interrupt Aggregator

This block gathers the per-mailbox "empty" and "full" level conditions of a set of shared mailboxes into one status word. The empty levels occupy the low byte and the full levels occupy the next byte. The block drives a small number of shared interrupt lines. Each line has its own enable mask, so software can route any combination of mailbox conditions to any line.

All conditions are levels. A status bit stays set for as long as its mailbox condition holds, and it drops on its own when the condition goes away. Software therefore masks a source that it has already serviced, rather than acknowledging it.

A read-only configuration word reports, in 4-bit fields, how many mailboxes, interrupt lines and other resource kinds are present. Access is over a simple 32-bit register bus. Reads are combinational from the address, and writes take effect at the clock edge.

Top module: `shirq_aggregator`

## Requirements
- R1: After synchronous reset, every enable mask reads 0 and every interrupt line is low.
- R2: The status word at offset 0x304 holds the empty level of mailbox i in bit i and the full level of mailbox i in bit 8+i. Bits 31:16 read 0. The word reflects the inputs one clock after they are applied.
- R3: Status bits for mailbox indices at or above MBOX_CNT read 0, whatever the inputs do.
- R4: The enable mask of interrupt line x sits at offset 0x100 + 4*x. A write stores write-data bits 15:0, a read returns them in bits 15:0 with bits 31:16 reading 0, and a write to one mask leaves the others unchanged.
- R5: Interrupt line x is high exactly when the status word ANDed with mask x is non-zero. It follows an input change one clock later, and a mask write also one clock later.
- R6: Writing 0 to a mask forces its line low from the next clock on, whatever the mailbox levels are.
- R7: Offset 0x300 always reads 0, and writes to it change no state.
- R8: Writes to the status offset 0x304 change neither the status word nor any mask.
- R9: Offset 0x380 reads the configuration word: mailbox count in 3:0, RES_B_CNT in 7:4, RES_C_CNT in 11:8, DOORBELL_CNT in 15:12, interrupt-line count in 19:16, and 0 above. Writes to it are ignored.
- R10: A status bit, and any line it drives, drops one clock after its input level falls. Nothing is latched.
- R11: Mask offsets at or above line index IRQ_CNT, misaligned offsets and unmapped offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_empty | input | MBOX_CNT | Per-mailbox empty level |
| mb_full | input | MBOX_CNT | Per-mailbox full level |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | IRQ_CNT | Shared interrupt lines |

## Verification
The bench builds the block with MBOX_CNT=5 and IRQ_CNT=3. With five mailboxes, all 1024 combinations of empty and full levels can be swept under several mask sets. The three unused status lanes per byte then show that they stay at 0. The mask index 3 lies past the last line, so the unmapped-mask path can be reached. Distinct counts of 2, 1 and 7 in the other configuration fields make a misplaced field visible.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned LANE_W      = 8;
    localparam int unsigned STAT_W      = 2 * LANE_W;
    localparam int unsigned MAX_LINES   = 16;

    localparam logic [ADDR_W-1:0] OFF_MASK_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_VECTOR    = 12'h300;
    localparam logic [ADDR_W-1:0] OFF_STATUS    = 12'h304;
    localparam logic [ADDR_W-1:0] OFF_CONFIG    = 12'h380;

    // status word layout: full levels above empty levels
    typedef struct packed {
        logic [LANE_W-1:0] full;
        logic [LANE_W-1:0] empty;
    } stat_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_VECTOR,
        SEL_CONFIG,
        SEL_MASK
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [3:0] idx;
    } dec_t;

    typedef struct packed {
        logic [3:0] lines;
        logic [3:0] doorbells;
        logic [3:0] res_c;
        logic [3:0] res_b;
        logic [3:0] mboxes;
    } cfg_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a[1:0] == 2'b00) begin
            if (a == OFF_STATUS) begin
                d.sel = SEL_STATUS;
            end else if (a == OFF_VECTOR) begin
                d.sel = SEL_VECTOR;
            end else if (a == OFF_CONFIG) begin
                d.sel = SEL_CONFIG;
            end else if (a[ADDR_W-1:6] == OFF_MASK_BASE[ADDR_W-1:6]) begin
                d.sel = SEL_MASK;
                d.idx = a[5:2];
            end
        end
        return d;
    endfunction

    function automatic logic [31:0] pack_cfg(input int unsigned mb, input int unsigned rb,
                                             input int unsigned rc, input int unsigned db,
                                             input int unsigned ln);
        cfg_t c;
        c.mboxes    = mb[3:0];
        c.res_b     = rb[3:0];
        c.res_c     = rc[3:0];
        c.doorbells = db[3:0];
        c.lines     = ln[3:0];
        return {12'h000, c};
    endfunction

endpackage

// File: rtl/shirq_level_sampler.sv
module shirq_level_sampler
    import shirq_pkg::*;
#(
    parameter int unsigned MBOX_CNT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MBOX_CNT-1:0] mb_empty,
    input  logic [MBOX_CNT-1:0] mb_full,
    output stat_t               stat_q
);

    logic [LANE_W-1:0] empty_pad;
    logic [LANE_W-1:0] full_pad;

    // lanes past the configured count are tied low
    always_comb begin
        empty_pad = '0;
        full_pad  = '0;
        empty_pad[MBOX_CNT-1:0] = mb_empty;
        full_pad[MBOX_CNT-1:0]  = mb_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.empty <= empty_pad;
            stat_q.full  <= full_pad;
        end
    end

endmodule

// File: rtl/shirq_mask_bank.sv
module shirq_mask_bank
    import shirq_pkg::*;
#(
    parameter int unsigned IRQ_CNT = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  dec_t                           dec,
    input  logic [STAT_W-1:0]              wdata,
    output logic [IRQ_CNT-1:0][STAT_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr && dec.sel == SEL_MASK) begin
            for (int x = 0; x < IRQ_CNT; x++) begin
                if (dec.idx == x[3:0]) begin
                    mask_q[x] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/shirq_line_reduce.sv
module shirq_line_reduce
    import shirq_pkg::*;
#(
    parameter int unsigned IRQ_CNT = 4
) (
    input  stat_t                          stat_q,
    input  logic [IRQ_CNT-1:0][STAT_W-1:0] mask_q,
    output logic [IRQ_CNT-1:0]             irq_out
);

    for (genvar gx = 0; gx < IRQ_CNT; gx++) begin : g_line
        assign irq_out[gx] = |(stat_q & mask_q[gx]);
    end

endmodule

// File: rtl/shirq_read_mux.sv
module shirq_read_mux
    import shirq_pkg::*;
#(
    parameter int unsigned IRQ_CNT = 4,
    parameter logic [31:0] CFG_WORD = 32'h0
) (
    input  dec_t                           dec,
    input  stat_t                          stat_q,
    input  logic [IRQ_CNT-1:0][STAT_W-1:0] mask_q,
    output logic [31:0]                    rdata
);

    always_comb begin
        rdata = '0;
        unique case (dec.sel)
            SEL_STATUS: rdata = {16'h0000, stat_q};
            SEL_CONFIG: rdata = CFG_WORD;
            SEL_MASK: begin
                for (int x = 0; x < IRQ_CNT; x++) begin
                    if (dec.idx == x[3:0]) begin
                        rdata = {16'h0000, mask_q[x]};
                    end
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/shirq_aggregator.sv
module shirq_aggregator
    import shirq_pkg::*;
#(
    parameter int unsigned MBOX_CNT     = 8,
    parameter int unsigned IRQ_CNT      = 4,
    parameter int unsigned RES_B_CNT    = 0,
    parameter int unsigned RES_C_CNT    = 0,
    parameter int unsigned DOORBELL_CNT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MBOX_CNT-1:0] mb_empty,
    input  logic [MBOX_CNT-1:0] mb_full,
    input  logic [11:0]         reg_addr,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [IRQ_CNT-1:0]  irq_out
);

    localparam logic [31:0] CFG_WORD =
        pack_cfg(MBOX_CNT, RES_B_CNT, RES_C_CNT, DOORBELL_CNT, IRQ_CNT);

    dec_t                           dec;
    stat_t                          stat_q;
    logic [IRQ_CNT-1:0][STAT_W-1:0] mask_q;
    logic                           unused_wdata_hi;

    assign dec             = decode_addr(reg_addr);
    assign unused_wdata_hi = ^reg_wdata[31:STAT_W];

    shirq_level_sampler #(.MBOX_CNT(MBOX_CNT)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .mb_empty (mb_empty),
        .mb_full  (mb_full),
        .stat_q   (stat_q)
    );

    shirq_mask_bank #(.IRQ_CNT(IRQ_CNT)) u_masks (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .dec    (dec),
        .wdata  (reg_wdata[STAT_W-1:0]),
        .mask_q (mask_q)
    );

    shirq_line_reduce #(.IRQ_CNT(IRQ_CNT)) u_reduce (
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .irq_out (irq_out)
    );

    shirq_read_mux #(.IRQ_CNT(IRQ_CNT), .CFG_WORD(CFG_WORD)) u_rmux (
        .dec    (dec),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .rdata  (reg_rdata)
    );

endmodule

// File: rtl/shirq_aggregator_chk.sv
module shirq_aggregator_chk
    import shirq_pkg::*;
#(
    parameter int unsigned MBOX_CNT     = 8,
    parameter int unsigned IRQ_CNT      = 4,
    parameter int unsigned RES_B_CNT    = 0,
    parameter int unsigned RES_C_CNT    = 0,
    parameter int unsigned DOORBELL_CNT = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic [MBOX_CNT-1:0]            mb_empty,
    input logic [MBOX_CNT-1:0]            mb_full,
    input logic [11:0]                    reg_addr,
    input logic                           reg_wr,
    input logic [STAT_W-1:0]              wdata_lo,
    input logic [31:0]                    reg_rdata,
    input logic [IRQ_CNT-1:0]             irq_out,
    input logic [IRQ_CNT-1:0][STAT_W-1:0] mask_q,
    input stat_t                          stat_q
);

    logic [STAT_W-1:0] lvl_now;
    always_comb begin
        lvl_now = '0;
        lvl_now[MBOX_CNT-1:0]          = mb_empty;
        lvl_now[LANE_W +: MBOX_CNT]    = mb_full;
    end

    // R2 / R10: status equals the previous cycle's levels
    a_r2_status_tracks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat_q == $past(lvl_now)));

    // R7: vector offset reads zero
    a_r7_vector_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_VECTOR) |-> (reg_rdata == 32'h0));

    // R9: configuration word fields
    a_r9_config_word: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_CONFIG) |-> (reg_rdata[3:0] == MBOX_CNT[3:0] &&
                                      reg_rdata[19:16] == IRQ_CNT[3:0] &&
                                      reg_rdata[31:20] == 12'h0));

    for (genvar gx = 0; gx < IRQ_CNT; gx++) begin : g_line_chk
        localparam logic [11:0] MY_OFF = OFF_MASK_BASE + 12'(4 * gx);

        // R1: first cycle after reset is quiet
        a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !irq_out[gx]);

        // R5: line equals masked levels of the previous cycle
        a_r5_line_value: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (irq_out[gx] == |($past(lvl_now) & mask_q[gx])));

        // R6: zero mask silences the line
        a_r6_zero_masks: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == MY_OFF && wdata_lo == '0) |=> !irq_out[gx]);

        // R4 / R8 / R11: a mask only changes on a write to its own offset
        a_r4_mask_holds: assert property (@(posedge clk) disable iff (rst)
            !(reg_wr && reg_addr == MY_OFF) |=> $stable(mask_q[gx]));
    end

endmodule

bind shirq_aggregator shirq_aggregator_chk #(
    .MBOX_CNT(MBOX_CNT), .IRQ_CNT(IRQ_CNT), .RES_B_CNT(RES_B_CNT),
    .RES_C_CNT(RES_C_CNT), .DOORBELL_CNT(DOORBELL_CNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mb_empty  (mb_empty),
    .mb_full   (mb_full),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wdata_lo  (reg_wdata[15:0]),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
);

// File: tb/sim_shirq_aggregator.sv
module sim_shirq_aggregator;

    localparam int NMB = 5;
    localparam int NLN = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NMB-1:0]  mb_empty = '0;
    logic [NMB-1:0]  mb_full  = '0;
    logic [11:0]     reg_addr = '0;
    logic            reg_wr   = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NLN-1:0]  irq_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [15:0] mask_model [NLN];

    always #5 clk = ~clk;

    shirq_aggregator #(
        .MBOX_CNT(NMB), .IRQ_CNT(NLN), .RES_B_CNT(2), .RES_C_CNT(1), .DOORBELL_CNT(7)
    ) u0 (
        .clk(clk), .rst(rst), .mb_empty(mb_empty), .mb_full(mb_full),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    function automatic logic [15:0] exp_stat(input logic [NMB-1:0] e, input logic [NMB-1:0] f);
        return {3'b000, f, 3'b000, e};
    endfunction

    function automatic logic [NLN-1:0] exp_irq(input logic [15:0] s);
        logic [NLN-1:0] r;
        for (int x = 0; x < NLN; x++) r[x] = |(s & mask_model[x]);
        return r;
    endfunction

    task automatic set_mask(input int x, input logic [31:0] d);
        wr(12'h100 + 12'(4 * x), d);
        mask_model[x] = d[15:0];
    endtask

    task automatic check_masks(input string req);
        for (int x = 0; x < NLN; x++) begin
            reg_addr = 12'h100 + 12'(4 * x);
            #1;
            check(req, reg_rdata, {16'h0, mask_model[x]});
        end
    endtask

    // apply levels, then after one edge check status and lines
    task automatic apply(input string req, input logic [NMB-1:0] e, input logic [NMB-1:0] f);
        @(negedge clk);
        mb_empty = e;
        mb_full  = f;
        reg_addr = 12'h304;
        @(negedge clk);
        check(req, reg_rdata, {16'h0, exp_stat(e, f)});
        check(req, 32'(irq_out), 32'(exp_irq(exp_stat(e, f))));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int x = 0; x < NLN; x++) mask_model[x] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_masks("R1");
        check("R1", 32'(irq_out), 0);

        // R4 mask write / readback / isolation
        set_mask(1, 32'hABCD_1234);
        check_masks("R4");

        // R2 R3 R5 exhaustive sweep under several mask sets
        for (int b = 0; b < 4; b++) begin
            for (int x = 0; x < NLN; x++)
                set_mask(x, 32'(((b + 1) * 16'h1357) ^ (x * 16'h0F0F) ^ (b == 3 ? 16'hE0E0 : 16'h0)));
            for (int p = 0; p < 1024; p++)
                apply(b == 3 ? "R3" : "R5", p[4:0], p[9:5]);
        end

        // R6 zero mask silences its line with all levels high
        apply("R5", 5'h1F, 5'h1F);
        set_mask(0, 32'h0);
        check("R6", 32'(irq_out[0]), 0);
        apply("R6", 5'h1F, 5'h1F);

        // R10 levels drop without latching
        set_mask(2, 32'hFFFF);
        apply("R10", 5'h04, 5'h00);
        apply("R10", 5'h00, 5'h00);

        // R7 vector offset
        apply("R7", 5'h0A, 5'h11);
        wr(12'h300, 32'hFFFF_FFFF);
        reg_addr = 12'h300; #1;
        check("R7", reg_rdata, 0);
        check_masks("R7");

        // R8 status write ignored
        wr(12'h304, 32'h0000_0000);
        reg_addr = 12'h304; #1;
        check("R8", reg_rdata, {16'h0, exp_stat(5'h0A, 5'h11)});
        check_masks("R8");

        // R9 configuration word
        reg_addr = 12'h380; #1;
        check("R9", reg_rdata, 32'h0003_7125);
        wr(12'h380, 32'h0);
        reg_addr = 12'h380; #1;
        check("R9", reg_rdata, 32'h0003_7125);

        // R11 unmapped mask index, misaligned and stray offsets
        wr(12'h10C, 32'hFFFF_FFFF);
        reg_addr = 12'h10C; #1;
        check("R11", reg_rdata, 0);
        wr(12'h106, 32'h0000_FFFF);
        reg_addr = 12'h106; #1;
        check("R11", reg_rdata, 0);
        reg_addr = 12'h200; #1;
        check("R11", reg_rdata, 0);
        check_masks("R11");
        check("R11", 32'(irq_out), 32'(exp_irq(exp_stat(5'h0A, 5'h11))));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule